// File: doc/BRIEF.md
# Trace Start/Stop Trigger Controller

This block turns trigger events into instruction-trace control. Two kinds of source feed it. The first is a set of external trigger lines, each with its own programmable 4-bit action selector. The second is a set of debug-trigger channels from the hart, each carrying an action code directly. Recognised actions start tracing, stop tracing or request a notify. The block keeps the instruction-tracing state bit. For each retirement group (one clock cycle of retired instructions) it reports whether that group falls inside the trace window.

A small set of external trigger outputs can be programmed to pulse when tracing starts, when it stops, or on a notify (watchpoint) event. Software writes and reads back the two selector words through a simple register port. Illegal selector values are forced to zero when written, so software can find out what is supported by writing a value and reading it back. When a start and a stop arrive in the same cycle, the block traces that one retirement group and then leaves tracing off.

Top module: `trig_trace_ctrl`

## Requirements
- R1: After reset, `tracing`, `trace_window`, `notify_pulse`, `ext_trig_out` and `reg_rdata` are 0, and both selector words read back as 0.
- R2: A write to address 0 sets the action selector of input n from bits 4n+3:4n. The values 0, 2 (start), 3 (stop) and 4 (notify) are kept. Any other value is stored as 0. The nibble of any input index at or above N_IN always reads 0. `reg_rdata` shows the word at the address presented one cycle earlier, as it stood before any write in that same cycle.
- R3: A write to address 1 sets the event bitmap of output k from bits 4k+3:4k. Bit 0 selects start, bit 1 selects stop and bit 2 selects notify. Bit 3 always reads 0, and so does every nibble of an output index at or above N_OUT.
- R4: While `inst_trig_en` is 0, trigger inputs and debug channels have no effect. `tracing`, `trace_window`, `notify_pulse` and `ext_trig_out` behave as if no trigger had fired.
- R5: A start in cycle c sets `trace_window` in cycle c+1, which marks group c as traced. `tracing` is 1 from cycle c+1, unless a stop also occurs in cycle c.
- R6: A stop in cycle c while tracing keeps `trace_window` at 1 in cycle c+1, so group c is still traced. `tracing` is 0 from cycle c+1, and the window then closes.
- R7: A start and a stop in the same cycle c set `trace_window` for exactly that group (cycle c+1). `tracing` is 0 afterwards.
- R8: A notify in cycle c gives a one-cycle `notify_pulse` in cycle c+1. Debug codes 0, 1, 5 and 6 to 15 cause nothing.
- R9: Debug channel j acts only when `dbg_act_vld[j]` is 1, using the code at `dbg_act_code[4j+3:4j]`. The meaning of each code is the same as for an input selector.
- R10: `ext_trig_out[k]` is 1 in cycle c+1 exactly when cycle c contained an event selected in its bitmap. A start event means tracing was off and the group is traced. A stop event means tracing turns off after a traced group. A notify event is a notify request.
- R11: A read of address 2 returns the tracing state in bit 0, with all other bits 0. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inst_trig_en | input | 1 | Global enable for trace triggers |
| ext_trig_in | input | N_IN | External trigger lines, one per input |
| dbg_act_vld | input | N_DBG | Debug trigger channel fired |
| dbg_act_code | input | 4*N_DBG | Action code per debug channel |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 action word, 1 event word, 2 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| tracing | output | 1 | Instruction-tracing state bit |
| trace_window | output | 1 | Previous cycle's retirement group is traced |
| notify_pulse | output | 1 | Notify request seen last cycle |
| ext_trig_out | output | N_OUT | External trigger output pulses |

## Verification
Directed stimulus applies a lone start, a lone stop, start and stop together (from both the off and the on state), and notify. It does this from external inputs and from debug channels, which separates the three state transitions and shows which source paths are decoded. Unsupported debug codes, a valid code without its strobe, and triggers with the enable low show that nothing else moves the state. Writes of all-ones and of mixed nibbles show the per-slot legalisation and the fixed-zero slots. A long stretch of random triggers, writes and reads is then compared every cycle against a behavioural model, which exercises back-to-back events and writes that coincide with triggers.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int TRIG_SLOTS = 8;
  localparam int NIB_W      = 4;
  localparam int REG_W      = TRIG_SLOTS * NIB_W;

  localparam logic [3:0] ACT_NONE = 4'd0;
  localparam logic [3:0] ACT_ON   = 4'd2;
  localparam logic [3:0] ACT_OFF  = 4'd3;
  localparam logic [3:0] ACT_NTFY = 4'd4;

  localparam logic [1:0] RA_ACT  = 2'd0;
  localparam logic [1:0] RA_EV   = 2'd1;
  localparam logic [1:0] RA_STAT = 2'd2;

  // packed order gives bitmap positions: start=0, stop=1, notify=2
  typedef struct packed {
    logic ntfy;
    logic stop;
    logic start;
  } trig_ev_t;

  function automatic logic [3:0] legal_act(input logic [3:0] v);
    case (v)
      ACT_ON, ACT_OFF, ACT_NTFY: legal_act = v;
      default:                   legal_act = ACT_NONE;
    endcase
  endfunction
endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
  import trig_pkg::*;
#(
  parameter int   N_IN      = 8,
  parameter int   N_OUT     = 8,
  parameter logic HAS_WATCH = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic [1:0]           reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  input  logic                 tracing,
  output logic [4*N_IN-1:0]    act_sel,
  output logic [4*N_OUT-1:0]   ev_sel,
  output logic [REG_W-1:0]     reg_rdata
);
  localparam logic [3:0] EV_MASK = {1'b0, HAS_WATCH, 2'b11};

  logic [REG_W-1:0] act_q;
  logic [REG_W-1:0] ev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
      ev_q  <= '0;
    end else if (reg_wr) begin
      if (reg_addr == RA_ACT) begin
        for (int n = 0; n < TRIG_SLOTS; n++)
          act_q[4*n +: 4] <= (n < N_IN) ? legal_act(reg_wdata[4*n +: 4]) : ACT_NONE;
      end
      if (reg_addr == RA_EV) begin
        for (int k = 0; k < TRIG_SLOTS; k++)
          ev_q[4*k +: 4] <= (k < N_OUT) ? (reg_wdata[4*k +: 4] & EV_MASK) : 4'h0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        RA_ACT:  reg_rdata <= act_q;
        RA_EV:   reg_rdata <= ev_q;
        RA_STAT: reg_rdata <= {{(REG_W-1){1'b0}}, tracing};
        default: reg_rdata <= '0;
      endcase
    end
  end

  assign act_sel = act_q[4*N_IN-1:0];
  assign ev_sel  = ev_q[4*N_OUT-1:0];
endmodule

// File: rtl/trig_decode.sv
module trig_decode
  import trig_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int N_DBG = 2
) (
  input  logic               en,
  input  logic [N_IN-1:0]    ext_in,
  input  logic [4*N_IN-1:0]  act_sel,
  input  logic [N_DBG-1:0]   dbg_vld,
  input  logic [4*N_DBG-1:0] dbg_code,
  output logic               on_req,
  output logic               off_req,
  output logic               ntfy_req
);
  localparam int NSRC = N_IN + N_DBG;

  logic [NSRC-1:0] fire;
  logic [3:0]      code [NSRC];
  logic [NSRC-1:0] hit_on, hit_off, hit_nt;

  for (genvar i = 0; i < N_IN; i++) begin : g_ext
    assign fire[i] = ext_in[i];
    assign code[i] = act_sel[4*i +: 4];
  end

  for (genvar j = 0; j < N_DBG; j++) begin : g_dbg
    assign fire[N_IN+j] = dbg_vld[j];
    assign code[N_IN+j] = dbg_code[4*j +: 4];
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign hit_on[s]  = fire[s] && (code[s] == ACT_ON);
    assign hit_off[s] = fire[s] && (code[s] == ACT_OFF);
    assign hit_nt[s]  = fire[s] && (code[s] == ACT_NTFY);
  end

  assign on_req   = en && (|hit_on);
  assign off_req  = en && (|hit_off);
  assign ntfy_req = en && (|hit_nt);
endmodule

// File: rtl/trig_state.sv
module trig_state
  import trig_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     on_req,
  input  logic     off_req,
  input  logic     ntfy_req,
  output logic     tracing,
  output logic     window,
  output logic     notify_pulse,
  output trig_ev_t ev_now
);
  logic trc_q;

  // the group of this cycle is traced if already on or turned on now
  assign ev_now.start = on_req & ~trc_q;
  assign ev_now.stop  = off_req & (trc_q | on_req);
  assign ev_now.ntfy  = ntfy_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      trc_q        <= 1'b0;
      window       <= 1'b0;
      notify_pulse <= 1'b0;
    end else begin
      window       <= trc_q | on_req;
      notify_pulse <= ntfy_req;
      if (off_req)     trc_q <= 1'b0;
      else if (on_req) trc_q <= 1'b1;
    end
  end

  assign tracing = trc_q;
endmodule

// File: rtl/trig_out_map.sv
module trig_out_map
  import trig_pkg::*;
#(
  parameter int N_OUT = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  trig_ev_t           ev_now,
  input  logic [4*N_OUT-1:0] ev_sel,
  output logic [N_OUT-1:0]   ext_out
);
  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    logic q;
    always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= |(ev_sel[4*k +: 4] & {1'b0, ev_now});
    end
    assign ext_out[k] = q;
  end
endmodule

// File: rtl/trig_trace_ctrl.sv
module trig_trace_ctrl
  import trig_pkg::*;
#(
  parameter int   N_IN      = 6,
  parameter int   N_OUT     = 3,
  parameter int   N_DBG     = 2,
  parameter logic HAS_WATCH = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inst_trig_en,
  input  logic [N_IN-1:0]    ext_trig_in,
  input  logic [N_DBG-1:0]   dbg_act_vld,
  input  logic [4*N_DBG-1:0] dbg_act_code,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               tracing,
  output logic               trace_window,
  output logic               notify_pulse,
  output logic [N_OUT-1:0]   ext_trig_out
);
  logic [4*N_IN-1:0]  act_sel;
  logic [4*N_OUT-1:0] ev_sel;
  logic               on_req, off_req, ntfy_req;
  trig_ev_t           ev_now;

  trig_cfg_regs #(.N_IN(N_IN), .N_OUT(N_OUT), .HAS_WATCH(HAS_WATCH)) u_cfg (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .tracing(tracing),
    .act_sel(act_sel), .ev_sel(ev_sel), .reg_rdata(reg_rdata)
  );

  trig_decode #(.N_IN(N_IN), .N_DBG(N_DBG)) u_dec (
    .en(inst_trig_en), .ext_in(ext_trig_in), .act_sel(act_sel),
    .dbg_vld(dbg_act_vld), .dbg_code(dbg_act_code),
    .on_req(on_req), .off_req(off_req), .ntfy_req(ntfy_req)
  );

  trig_state u_st (
    .clk(clk), .rst(rst), .on_req(on_req), .off_req(off_req),
    .ntfy_req(ntfy_req), .tracing(tracing), .window(trace_window),
    .notify_pulse(notify_pulse), .ev_now(ev_now)
  );

  trig_out_map #(.N_OUT(N_OUT)) u_out (
    .clk(clk), .rst(rst), .ev_now(ev_now), .ev_sel(ev_sel),
    .ext_out(ext_trig_out)
  );
endmodule

// File: rtl/trig_trace_ctrl_chk.sv
module trig_trace_ctrl_chk
  import trig_pkg::*;
#(
  parameter int N_OUT = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             inst_trig_en,
  input logic             on_req,
  input logic             off_req,
  input logic             ntfy_req,
  input trig_ev_t         ev_now,
  input logic             tracing,
  input logic             trace_window,
  input logic             notify_pulse,
  input logic [N_OUT-1:0] ext_trig_out
);
  a_r5_start_opens: assert property (@(posedge clk) disable iff (rst)
    on_req && !off_req |=> trace_window && tracing);

  a_r6_stop_clears: assert property (@(posedge clk) disable iff (rst)
    off_req |=> !tracing);

  a_r6_idle_closed: assert property (@(posedge clk) disable iff (rst)
    !tracing && !on_req |=> !trace_window);

  a_r7_both_one_group: assert property (@(posedge clk) disable iff (rst)
    on_req && off_req |=> trace_window && !tracing);

  a_r4_disabled_hold: assert property (@(posedge clk) disable iff (rst)
    !inst_trig_en |=> (tracing == $past(tracing)) && !notify_pulse);

  a_r8_notify_pulse: assert property (@(posedge clk) disable iff (rst)
    ntfy_req |=> notify_pulse);

  a_r10_out_has_cause: assert property (@(posedge clk) disable iff (rst)
    (ext_trig_out != '0) |-> $past(ev_now != '0));
endmodule

bind trig_trace_ctrl trig_trace_ctrl_chk #(.N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst(rst), .inst_trig_en(inst_trig_en),
  .on_req(on_req), .off_req(off_req), .ntfy_req(ntfy_req),
  .ev_now(ev_now), .tracing(tracing), .trace_window(trace_window),
  .notify_pulse(notify_pulse), .ext_trig_out(ext_trig_out)
);

// File: tb/trig_trace_ctrl_bench.sv
`timescale 1ns/1ps
module trig_trace_ctrl_bench;
  localparam int N_IN = 6, N_OUT = 3, N_DBG = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inst_trig_en = 1'b0;
  logic [N_IN-1:0] ext_trig_in = '0;
  logic [N_DBG-1:0] dbg_act_vld = '0;
  logic [4*N_DBG-1:0] dbg_act_code = '0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic tracing, trace_window, notify_pulse;
  logic [N_OUT-1:0] ext_trig_out;

  always #2.5 clk = ~clk;

  trig_trace_ctrl #(.N_IN(N_IN), .N_OUT(N_OUT), .N_DBG(N_DBG)) u_trig_trace_ctrl (
    .clk(clk), .rst(rst), .inst_trig_en(inst_trig_en), .ext_trig_in(ext_trig_in),
    .dbg_act_vld(dbg_act_vld), .dbg_act_code(dbg_act_code), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tracing(tracing), .trace_window(trace_window), .notify_pulse(notify_pulse),
    .ext_trig_out(ext_trig_out)
  );

  int checks = 0, errors = 0;
  string phase = "R1";

  // behavioural reference
  int m_act[8];
  int m_ev[8];
  bit m_trc, m_win, m_ntf;
  bit [N_OUT-1:0] m_out;
  logic [31:0] m_rd;

  function automatic logic [31:0] pack_word(input int w[8]);
    logic [31:0] r = '0;
    for (int i = 0; i < 8; i++) r[4*i +: 4] = w[i][3:0];
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_act[i]) begin m_act[i] = 0; m_ev[i] = 0; end
      m_trc = 0; m_win = 0; m_ntf = 0; m_out = '0; m_rd = '0;
    end else begin
      bit on, off, nt, st, sp;
      int c;
      on = 0; off = 0; nt = 0;
      for (int n = 0; n < N_IN; n++)
        if (ext_trig_in[n]) begin
          c = m_act[n];
          if (c == 2) on = 1;
          if (c == 3) off = 1;
          if (c == 4) nt = 1;
        end
      for (int j = 0; j < N_DBG; j++)
        if (dbg_act_vld[j]) begin
          c = int'(dbg_act_code[4*j +: 4]);
          if (c == 2) on = 1;
          if (c == 3) off = 1;
          if (c == 4) nt = 1;
        end
      if (!inst_trig_en) begin on = 0; off = 0; nt = 0; end
      st = on && !m_trc;
      sp = off && (m_trc || on);
      for (int k = 0; k < N_OUT; k++)
        m_out[k] = ((m_ev[k] & 1) != 0 && st) || ((m_ev[k] & 2) != 0 && sp) ||
                   ((m_ev[k] & 4) != 0 && nt);
      m_win = m_trc || on;
      m_ntf = nt;
      if (off) m_trc = 0; else if (on) m_trc = 1;
      case (reg_addr)
        2'd0: m_rd = pack_word(m_act);
        2'd1: m_rd = pack_word(m_ev);
        2'd2: m_rd = {31'b0, !m_trc && off ? 1'b1 : 1'b0};
        default: m_rd = '0;
      endcase
      if (reg_addr == 2'd2) m_rd = {31'b0, m_rd_trc_prev};
      if (reg_wr && reg_addr == 2'd0)
        for (int n = 0; n < 8; n++) begin
          c = int'(reg_wdata[4*n +: 4]);
          m_act[n] = (n < N_IN && (c == 2 || c == 3 || c == 4)) ? c : 0;
        end
      if (reg_wr && reg_addr == 2'd1)
        for (int k = 0; k < 8; k++)
          m_ev[k] = (k < N_OUT) ? (int'(reg_wdata[4*k +: 4]) & 7) : 0;
      m_rd_trc_prev = m_trc;
    end
  end
  bit m_rd_trc_prev = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  bit run = 0;
  always @(negedge clk) if (run && !rst) begin
    chk(phase, "trace_window", {31'b0, trace_window}, {31'b0, m_win});
    chk(phase, "tracing", {31'b0, tracing}, {31'b0, m_rd_trc_prev});
    chk(phase, "notify_pulse", {31'b0, notify_pulse}, {31'b0, m_ntf});
    chk(phase, "ext_trig_out", 32'(ext_trig_out), 32'(m_out));
    chk(phase, "reg_rdata", reg_rdata, m_rd);
  end

  task automatic cyc(input bit en, input logic [N_IN-1:0] ins,
                     input logic [N_DBG-1:0] dv, input logic [4*N_DBG-1:0] dc,
                     input bit wr, input logic [1:0] a, input logic [31:0] d);
    inst_trig_en = en; ext_trig_in = ins; dbg_act_vld = dv; dbg_act_code = dc;
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    run = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "tracing", {31'b0, tracing}, 32'd0);
    chk("R1", "window", {31'b0, trace_window}, 32'd0);
    chk("R1", "ext_out", 32'(ext_trig_out), 32'd0);
    cyc(0, '0, '0, '0, 0, 2'd0, '0);
    chk("R1", "action word", reg_rdata, 32'd0);
    cyc(0, '0, '0, '0, 0, 2'd1, '0);
    chk("R1", "event word", reg_rdata, 32'd0);
    // R2 legalisation
    phase = "R2";
    cyc(0, '0, '0, '0, 1, 2'd0, 32'h1234_5432);
    cyc(0, '0, '0, '0, 0, 2'd0, '0);
    chk("R2", "action word", reg_rdata, 32'h0034_0432);
    cyc(0, '0, '0, '0, 1, 2'd0, 32'h0000_00F1);
    cyc(0, '0, '0, '0, 0, 2'd0, '0);
    chk("R2", "action word codes 1/15", reg_rdata, 32'h0000_0000);
    // R3 event bitmap
    phase = "R3";
    cyc(0, '0, '0, '0, 1, 2'd1, 32'hFFFF_FFFF);
    cyc(0, '0, '0, '0, 0, 2'd1, '0);
    chk("R3", "event word", reg_rdata, 32'h0000_0777);
    cyc(0, '0, '0, '0, 1, 2'd1, 32'h0000_0421);
    cyc(0, '0, '0, '0, 1, 2'd0, 32'h0032_0432);
    // R4 disabled
    phase = "R4";
    cyc(0, 6'b000101, '0, '0, 0, 2'd3, '0);
    chk("R4", "tracing", {31'b0, tracing}, 32'd0);
    chk("R4", "window", {31'b0, trace_window}, 32'd0);
    chk("R4", "notify", {31'b0, notify_pulse}, 32'd0);
    chk("R4", "ext_out", 32'(ext_trig_out), 32'd0);
    // R5 start
    phase = "R5";
    cyc(1, 6'b000001, '0, '0, 0, 2'd3, '0);
    chk("R5", "window", {31'b0, trace_window}, 32'd1);
    chk("R5", "tracing", {31'b0, tracing}, 32'd1);
    chk("R10", "start pulse", 32'(ext_trig_out), 32'b001);
    cyc(1, '0, '0, '0, 0, 2'd3, '0);
    chk("R10", "single pulse", 32'(ext_trig_out), 32'b000);
    // R11 status read
    phase = "R11";
    cyc(1, '0, '0, '0, 0, 2'd2, '0);
    chk("R11", "status", reg_rdata, 32'd1);
    // R6 stop
    phase = "R6";
    cyc(1, 6'b000010, '0, '0, 0, 2'd3, '0);
    chk("R6", "window last group", {31'b0, trace_window}, 32'd1);
    chk("R6", "tracing", {31'b0, tracing}, 32'd0);
    chk("R10", "stop pulse", 32'(ext_trig_out), 32'b010);
    cyc(1, '0, '0, '0, 0, 2'd3, '0);
    chk("R6", "window closed", {31'b0, trace_window}, 32'd0);
    // R7 both
    phase = "R7";
    cyc(1, 6'b000011, '0, '0, 0, 2'd3, '0);
    chk("R7", "window", {31'b0, trace_window}, 32'd1);
    chk("R7", "tracing", {31'b0, tracing}, 32'd0);
    chk("R7", "ext_out", 32'(ext_trig_out), 32'b011);
    cyc(1, '0, '0, '0, 0, 2'd3, '0);
    chk("R7", "window after", {31'b0, trace_window}, 32'd0);
    cyc(1, 6'b010000, '0, '0, 0, 2'd3, '0);
    cyc(1, 6'b110000, '0, '0, 0, 2'd3, '0);
    chk("R7", "both while on", 32'(ext_trig_out), 32'b010);
    chk("R7", "tracing off", {31'b0, tracing}, 32'd0);
    // R8 notify and ignored codes
    phase = "R8";
    cyc(1, 6'b000100, '0, '0, 0, 2'd3, '0);
    chk("R8", "notify", {31'b0, notify_pulse}, 32'd1);
    chk("R10", "notify out", 32'(ext_trig_out), 32'b100);
    cyc(1, '0, 2'b11, {4'd5, 4'd1}, 0, 2'd3, '0);
    chk("R8", "codes 5/1", {31'b0, notify_pulse | tracing | trace_window}, 32'd0);
    cyc(1, '0, 2'b11, {4'd0, 4'd9}, 0, 2'd3, '0);
    chk("R8", "codes 0/9", {31'b0, notify_pulse | tracing | trace_window}, 32'd0);
    // R9 debug channels
    phase = "R9";
    cyc(1, '0, 2'b00, {4'd2, 4'd2}, 0, 2'd3, '0);
    chk("R9", "no strobe", {31'b0, tracing}, 32'd0);
    cyc(1, '0, 2'b01, {4'd0, 4'd2}, 0, 2'd3, '0);
    chk("R9", "dbg start", {31'b0, tracing}, 32'd1);
    cyc(1, '0, 2'b10, {4'd3, 4'd0}, 0, 2'd3, '0);
    chk("R9", "dbg stop", {31'b0, tracing}, 32'd0);
    cyc(1, '0, 2'b10, {4'd4, 4'd0}, 0, 2'd3, '0);
    chk("R9", "dbg notify", {31'b0, notify_pulse}, 32'd1);
    // R10 random mix against the model
    phase = "R10";
    for (int i = 0; i < 600; i++) begin
      logic [31:0] rw;
      rw = $urandom;
      cyc(($urandom % 4) != 0, N_IN'($urandom & $urandom), N_DBG'($urandom),
          (4*N_DBG)'($urandom % 5 | (($urandom % 5) << 4)),
          ($urandom % 8) == 0, 2'($urandom), rw);
    end
    cyc(0, '0, '0, '0, 0, 2'd3, '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule